// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Protocol Controller

This block is the slave-side protocol engine of a small serial EEPROM on a two-wire bus. It runs on the system clock. Its inputs are SCL and SDA levels that have already been filtered and oversampled, together with one-cycle START and STOP strobes from a bus-condition detector. Its only bus output is an enable for the open-drain pull-down on SDA. Its other outputs go to two neighbours: per-byte write requests to a page-buffer write engine, and a read address to a 256-byte memory with a combinational read port.

Each control byte must carry the device code. The three chip-select bits that follow it are ignored. A single address pointer serves reads and writes, so a read with no address continues from wherever the last access left off. While the write engine reports busy, the block acknowledges nothing, not even its own control byte. A bus master can therefore poll with control bytes until the write finishes.

Top module: `eeprom_slave_ctrl`

## Requirements
- R1: A control byte is accepted only when its bits 7:4 are 1010. Bits 3:1 are ignored. Bit 0 selects read (1) or write (0).
- R2: After an accepted byte, sda_pull_o goes high on the SCL fall that ends the 8th bit. It stays high through the 9th SCL high phase and drops on the 9th SCL fall.
- R3: While busy_i is high, no byte is acknowledged, including the control byte. The block then ignores the bus until the next START, and the address pointer is unchanged.
- R4: In a write, the first byte after the control byte loads the address pointer. Each later byte produces a one-cycle wr_req_o with wr_addr_o equal to the pointer and wr_data_o equal to the byte.
- R5: After each written data byte, only the low 3 pointer bits count up and wrap; the upper 5 bits hold. A burst of 4 bytes from 0x46 therefore targets 0x46, 0x47, 0x40 and 0x41.
- R6: wr_commit_o pulses for one cycle after a STOP that ends a write carrying at least one data byte. A write of the address byte alone produces no pulse.
- R7: A repeated START after the address byte ends the write, and the pointer keeps the loaded value. A following read returns the byte at that address.
- R8: A read sends the byte at the pointer, most significant bit first, and then advances the pointer by one across the whole array, with 0xFF wrapping to 0x00. After any access to address n, the next read without an address returns the byte at n+1.
- R9: A master acknowledge (SDA low in the 9th clock) after a read byte starts the next sequential byte. A missing acknowledge releases SDA and leaves the block idle.
- R10: A START or STOP in the middle of a byte abandons the transaction and clears the bit count. A partly received address byte does not change the pointer.
- R11: After a control byte without the device code, the block drives nothing and requests nothing until the next START.
- R12: SDA is shifted in on SCL rising edges. sda_pull_o changes only in the clock after an SCL fall, or after a START or STOP strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Filtered SCL level |
| sda_i | input | 1 | Filtered SDA level (wired bus value) |
| start_i | input | 1 | One-cycle START condition strobe |
| stop_i | input | 1 | One-cycle STOP condition strobe |
| busy_i | input | 1 | Write engine programming in progress |
| mem_rdata_i | input | 8 | Memory read data for mem_raddr_o (combinational) |
| sda_pull_o | output | 1 | Enable for the open-drain SDA pull-down |
| mem_raddr_o | output | 8 | Memory read address (current pointer) |
| wr_req_o | output | 1 | One-cycle write request for one data byte |
| wr_addr_o | output | 8 | Byte address of the write request |
| wr_data_o | output | 8 | Data of the write request |
| wr_commit_o | output | 1 | One-cycle pulse: start programming the buffered page |

## Verification
Every output is registered once behind the SCL edge detector. sda_pull_o, wr_req_o and the write address and data therefore move in the clock that samples the SCL fall, and wr_commit_o moves in the clock that samples the STOP strobe. The bench drives the bus one nanosecond after a rising edge and holds each SCL phase for several clocks. It reads SDA and the request log only after at least two clocks of settling, well inside the SCL high phase or after the phase ends. A monitor on the falling clock edge checks that the pull-down never changes while SCL is high, except just after a START or STOP strobe.

// File: rtl/eeprom_slv_pkg.sv
package eeprom_slv_pkg;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 8;
    localparam int CNT_W  = $clog2(DATA_W + 1);
    localparam logic [3:0] DEV_CODE = 4'b1010;

    typedef enum logic [2:0] {
        ST_IDLE, ST_RX, ST_RX_ACK, ST_TX, ST_TX_ACK
    } st_e;

    typedef enum logic [1:0] {
        RK_CTRL, RK_ADDR, RK_DATA
    } rk_e;

    typedef struct packed {
        st_e               st;
        rk_e               rk;
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] sh;
        logic [ADDR_W-1:0] ptr;
        logic              rd;
        logic              pull;
        logic              mack;
        logic              pend;
        logic              wreq;
        logic [ADDR_W-1:0] wa;
        logic [DATA_W-1:0] wd;
        logic              commit;
    } slv_state_t;
endpackage

// File: rtl/eeprom_scl_edge.sv
module eeprom_scl_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    output logic rise_o,
    output logic fall_o
);
    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= scl_i;
    end

    assign rise_o = scl_i & ~prev_q;
    assign fall_o = ~scl_i & prev_q;
endmodule

// File: rtl/eeprom_ptr_step.sv
module eeprom_ptr_step #(
    parameter int W         = 8,
    parameter int WRAP_BITS = 3
) (
    input  logic [W-1:0] cur_i,
    output logic [W-1:0] nxt_o
);
    generate
        if (WRAP_BITS >= W) begin : g_full
            assign nxt_o = cur_i + W'(1);
        end else begin : g_page
            assign nxt_o = {cur_i[W-1:WRAP_BITS], cur_i[WRAP_BITS-1:0] + WRAP_BITS'(1)};
        end
    endgenerate
endmodule

// File: rtl/eeprom_slave_ctrl.sv
module eeprom_slave_ctrl
    import eeprom_slv_pkg::*;
#(
    parameter int PAGE_BITS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic              busy_i,
    input  logic [DATA_W-1:0] mem_rdata_i,
    output logic              sda_pull_o,
    output logic [ADDR_W-1:0] mem_raddr_o,
    output logic              wr_req_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [DATA_W-1:0] wr_data_o,
    output logic              wr_commit_o
);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W);

    slv_state_t q, d;
    logic scl_rise, scl_fall;
    logic [ADDR_W-1:0] ptr_page_nxt, ptr_full_nxt;

    eeprom_scl_edge u_edge (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i),
        .rise_o(scl_rise), .fall_o(scl_fall)
    );

    eeprom_ptr_step #(.W(ADDR_W), .WRAP_BITS(PAGE_BITS)) u_page_step (
        .cur_i(q.ptr), .nxt_o(ptr_page_nxt)
    );

    eeprom_ptr_step #(.W(ADDR_W), .WRAP_BITS(ADDR_W)) u_full_step (
        .cur_i(q.ptr), .nxt_o(ptr_full_nxt)
    );

    always_comb begin
        d = q;
        d.wreq   = 1'b0;
        d.commit = 1'b0;
        if (stop_i) begin
            d.st     = ST_IDLE;
            d.pull   = 1'b0;
            d.cnt    = '0;
            d.commit = q.pend;
            d.pend   = 1'b0;
        end else if (start_i) begin
            d.st   = ST_RX;
            d.rk   = RK_CTRL;
            d.cnt  = '0;
            d.pull = 1'b0;
            d.pend = 1'b0;
        end else begin
            case (q.st)
                ST_RX: begin
                    if (scl_rise) begin
                        d.sh  = {q.sh[DATA_W-2:0], sda_i};
                        d.cnt = q.cnt + CNT_W'(1);
                    end else if (scl_fall && q.cnt == LAST_BIT) begin
                        d.cnt = '0;
                        if (busy_i) begin
                            d.st = ST_IDLE;
                        end else begin
                            case (q.rk)
                                RK_CTRL: begin
                                    if (q.sh[DATA_W-1:DATA_W-4] == DEV_CODE) begin
                                        d.rd   = q.sh[0];
                                        d.pull = 1'b1;
                                        d.st   = ST_RX_ACK;
                                    end else begin
                                        d.st = ST_IDLE;
                                    end
                                end
                                RK_ADDR: begin
                                    d.ptr  = q.sh;
                                    d.pull = 1'b1;
                                    d.st   = ST_RX_ACK;
                                end
                                default: begin
                                    d.wreq = 1'b1;
                                    d.wa   = q.ptr;
                                    d.wd   = q.sh;
                                    d.ptr  = ptr_page_nxt;
                                    d.pend = 1'b1;
                                    d.pull = 1'b1;
                                    d.st   = ST_RX_ACK;
                                end
                            endcase
                        end
                    end
                end
                ST_RX_ACK: begin
                    if (scl_fall) begin
                        d.pull = 1'b0;
                        d.cnt  = '0;
                        if (q.rk == RK_CTRL && q.rd) begin
                            d.st   = ST_TX;
                            d.sh   = mem_rdata_i;
                            d.ptr  = ptr_full_nxt;
                            d.pull = ~mem_rdata_i[DATA_W-1];
                        end else begin
                            d.st = ST_RX;
                            d.rk = (q.rk == RK_CTRL) ? RK_ADDR : RK_DATA;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_rise) begin
                        d.cnt = q.cnt + CNT_W'(1);
                    end else if (scl_fall) begin
                        if (q.cnt == LAST_BIT) begin
                            d.pull = 1'b0;
                            d.st   = ST_TX_ACK;
                        end else begin
                            d.sh   = {q.sh[DATA_W-2:0], 1'b0};
                            d.pull = ~q.sh[DATA_W-2];
                        end
                    end
                end
                ST_TX_ACK: begin
                    if (scl_rise) begin
                        d.mack = ~sda_i;
                    end else if (scl_fall) begin
                        d.cnt = '0;
                        if (q.mack) begin
                            d.st   = ST_TX;
                            d.sh   = mem_rdata_i;
                            d.ptr  = ptr_full_nxt;
                            d.pull = ~mem_rdata_i[DATA_W-1];
                        end else begin
                            d.st = ST_IDLE;
                        end
                    end
                end
                default: d.pull = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, rk: RK_CTRL, default: '0};
        end else begin
            q <= d;
        end
    end

    assign sda_pull_o  = q.pull;
    assign mem_raddr_o = q.ptr;
    assign wr_req_o    = q.wreq;
    assign wr_addr_o   = q.wa;
    assign wr_data_o   = q.wd;
    assign wr_commit_o = q.commit;

    // R3: a byte completed while busy is never acknowledged
    a_r3_no_ack_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_RX && scl_fall && q.cnt == LAST_BIT && busy_i && !start_i && !stop_i)
        |=> !sda_pull_o);

    // R10: bus conditions restart the bit count
    a_r10_event_clears_count: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i || stop_i) |=> (q.cnt == '0));

    // R12: the SDA drive moves only behind an SCL fall or a bus condition
    a_r12_drive_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_pull_o) |-> $past(scl_fall || start_i || stop_i));

    // R4: write requests come only from data bytes of a write
    a_r4_wreq_from_data: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req_o |-> (q.rk == RK_DATA && q.st == ST_RX_ACK && !q.rd));

    // R6: commit is always the consequence of a STOP
    a_r6_commit_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
        wr_commit_o |-> $past(stop_i));

    // R11: an idle slave never holds SDA
    a_r11_idle_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IDLE) |-> !sda_pull_o);

    // R2: the bit counter never passes the acknowledge slot
    a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= LAST_BIT);
endmodule

// File: tb/sim_eeprom_slave_ctrl.sv
module sim_eeprom_slave_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1, sda_m = 1'b1, start_s = 1'b0, stop_s = 1'b0, busy = 1'b0;
    logic sda_line, sda_pull_o, wr_req_o, wr_commit_o;
    logic [7:0] mem_raddr_o, wr_addr_o, wr_data_o, mem_rdata;
    logic [7:0] mem [256];
    logic [7:0] wlog_a [16];
    logic [7:0] wlog_d [16];
    int wn = 0, commits = 0, tests = 0, fails = 0, viol = 0;
    logic mon_pull = 1'b0, mon_strobe = 1'b0;
    bit done = 0;

    always #4 clk = ~clk;

    assign sda_line  = sda_m & ~sda_pull_o;
    assign mem_rdata = mem[mem_raddr_o];

    eeprom_slave_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
        .start_i(start_s), .stop_i(stop_s), .busy_i(busy),
        .mem_rdata_i(mem_rdata), .sda_pull_o(sda_pull_o),
        .mem_raddr_o(mem_raddr_o), .wr_req_o(wr_req_o),
        .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o), .wr_commit_o(wr_commit_o)
    );

    always @(negedge clk) begin
        if (wr_req_o && wn < 16) begin
            wlog_a[wn] = wr_addr_o;
            wlog_d[wn] = wr_data_o;
            wn = wn + 1;
        end
        if (wr_commit_o) commits = commits + 1;
        if (rst_n && sda_pull_o != mon_pull && scl && !mon_strobe) viol = viol + 1;
        mon_pull   = sda_pull_o;
        mon_strobe = start_s | stop_s;
    end

    task automatic tick(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(2); scl = 1'b1; tick(3);
        sda_m = 1'b0; start_s = 1'b1; tick(1); start_s = 1'b0; tick(2);
        scl = 1'b0; tick(2);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(2); scl = 1'b1; tick(2);
        sda_m = 1'b1; stop_s = 1'b1; tick(1); stop_s = 1'b0; tick(3);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sda_m = b[i]; tick(2); scl = 1'b1; tick(3); scl = 1'b0; tick(1);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        send_bits(b, 8);
        sda_m = 1'b1; tick(2); scl = 1'b1; tick(2);
        acked = !sda_line; tick(2); scl = 1'b0; tick(2);
    endtask

    task automatic recv_byte(input bit mack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            tick(2); scl = 1'b1; tick(2); b[i] = sda_line; tick(2); scl = 1'b0;
        end
        tick(1); sda_m = mack ? 1'b0 : 1'b1; tick(2); scl = 1'b1; tick(3);
        scl = 1'b0; tick(1); sda_m = 1'b1;
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
    endtask

    localparam logic [15:0] RR_TAB [6] = '{
        {8'h00, 8'h5A}, {8'h13, 8'h49}, {8'h7F, 8'h25},
        {8'h80, 8'hDA}, {8'hC4, 8'h9E}, {8'hFE, 8'hA4}
    };

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            summary();
            $finish;
        end
    end

    initial begin
        bit a;
        logic [7:0] b;
        int c0;
        for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h5A;
        tick(4);
        chk(sda_pull_o == 0 && wr_req_o == 0 && wr_commit_o == 0, "R2 reset", sda_pull_o, 0);
        rst_n = 1'b1; tick(3);

        // R7 random reads walked from the table
        foreach (RR_TAB[k]) begin
            bus_start();
            send_byte(8'hA0, a); chk(a, "R1 ctrl ack", a, 1);
            chk(sda_pull_o == 0, "R2 release after 9th", sda_pull_o, 0);
            send_byte(RR_TAB[k][15:8], a); chk(a, "R4 addr ack", a, 1);
            bus_start();
            send_byte(8'hA1, a); chk(a, "R1 read ctrl ack", a, 1);
            recv_byte(1'b0, b); chk(b == RR_TAB[k][7:0], "R7 random read", b, RR_TAB[k][7:0]);
            bus_stop();
        end

        // R8 current-address reads and full-array wrap
        bus_start(); send_byte(8'hA1, a); recv_byte(1'b0, b); bus_stop();
        chk(b == 8'hA5, "R8 n+1 read", b, 8'hA5);
        bus_start(); send_byte(8'hA1, a); recv_byte(1'b0, b); bus_stop();
        chk(b == 8'h5A, "R8 wrap to 0", b, 8'h5A);

        // R9 sequential read
        bus_start(); send_byte(8'hA0, a); send_byte(8'h20, a);
        bus_start(); send_byte(8'hA1, a);
        recv_byte(1'b1, b); chk(b == 8'h7A, "R9 seq 0", b, 8'h7A);
        recv_byte(1'b1, b); chk(b == 8'h7B, "R9 seq 1", b, 8'h7B);
        recv_byte(1'b1, b); chk(b == 8'h78, "R9 seq 2", b, 8'h78);
        recv_byte(1'b0, b); chk(b == 8'h79, "R9 seq 3", b, 8'h79);
        tick(4); chk(sda_pull_o == 0, "R9 release on nack", sda_pull_o, 0);
        bus_stop();

        // R4 R6 byte write with chip-select bits set
        c0 = commits;
        bus_start(); send_byte(8'hAE, a); chk(a, "R1 cs bits ignored", a, 1);
        send_byte(8'h40, a); send_byte(8'h33, a); chk(a, "R2 data ack", a, 1);
        chk(wn == 1 && wlog_a[0] == 8'h40 && wlog_d[0] == 8'h33, "R4 byte write", {wlog_a[0], wlog_d[0]}, 16'h4033);
        bus_stop();
        chk(commits == c0 + 1, "R6 commit on stop", commits, c0 + 1);

        // R5 page write wrapping inside the page
        bus_start(); send_byte(8'hA0, a); send_byte(8'h46, a);
        send_byte(8'h11, a); send_byte(8'h22, a); send_byte(8'h33, a); send_byte(8'h44, a);
        bus_stop();
        chk(wn == 5, "R5 request count", wn, 5);
        chk(wlog_a[1] == 8'h46 && wlog_a[2] == 8'h47 && wlog_a[3] == 8'h40 && wlog_a[4] == 8'h41,
            "R5 page wrap", {wlog_a[3], wlog_a[4]}, 16'h4041);
        chk(wlog_d[4] == 8'h44, "R4 page data", wlog_d[4], 8'h44);
        bus_start(); send_byte(8'hA1, a); recv_byte(1'b0, b); bus_stop();
        chk(b == 8'h18, "R8 after page write", b, 8'h18);

        // R6 address-only write gives no commit
        c0 = commits;
        bus_start(); send_byte(8'hA0, a); send_byte(8'h10, a); bus_stop();
        chk(commits == c0, "R6 no commit without data", commits, c0);

        // R3 acknowledge polling while busy
        busy = 1'b1;
        bus_start(); send_byte(8'hA0, a); chk(!a, "R3 no ack when busy", a, 0);
        send_byte(8'h77, a); chk(!a && wn == 5, "R3 bus ignored", wn, 5);
        bus_stop(); busy = 1'b0;
        bus_start(); send_byte(8'hA1, a); chk(a, "R3 ack after busy", a, 1);
        recv_byte(1'b0, b); bus_stop();
        chk(b == 8'h4A, "R3 pointer kept", b, 8'h4A);

        // R11 device code mismatch
        bus_start(); send_byte(8'h51, a); chk(!a, "R11 mismatch nack", a, 0);
        send_byte(8'hA1, a); chk(!a && sda_pull_o == 0, "R11 ignored until start", a, 0);
        bus_stop();

        // R10 START inside a byte
        bus_start(); send_bits(8'hF0, 4);
        bus_start(); send_byte(8'hA1, a); chk(a, "R10 restart after abort", a, 1);
        recv_byte(1'b0, b); bus_stop();
        chk(b == 8'h4B, "R10 read after abort", b, 8'h4B);

        // R10 STOP inside the address byte
        bus_start(); send_byte(8'hA0, a); send_bits(8'hE0, 3); bus_stop();
        bus_start(); send_byte(8'hA1, a); recv_byte(1'b0, b); bus_stop();
        chk(b == 8'h48, "R10 partial address dropped", b, 8'h48);
        chk(wn == 5, "R11 no stray requests", wn, 5);

        chk(viol == 0, "R12 drive only after fall", viol, 0);
        done = 1;
        summary();
        $finish;
    end
endmodule